// File: doc/BRIEF.md
# Half-Word to Word Settings Write Bridge

This block sits on a 16-bit register bus as a slave and turns pairs of half-word writes into single 32-bit writes on an internal settings bus. The settings bus has 64 write-only registers. Each register takes four bytes of the bridge's byte address window, so register n sits at window offset 4·n. Software writes the lower half of a register at offset +0, where the bridge holds it in a staging register. It then writes the upper half at offset +2. That second write makes the bridge emit a one-cycle strobe that carries the register index and the full 32-bit word.

The bridge acknowledges every bus access one cycle after it is presented, so the bus never stalls. It returns zero on reads. Accesses whose upper address bits do not select the bridge's window are acknowledged and otherwise have no effect, and so are misaligned accesses. The settings outputs are registered and hold their last values between strobes.

Top module: `sb_bridge_16to32`

## Requirements
- R1: After reset, `sr_stb` and `bus_ack` are 0, `sr_addr` and `sr_data` are 0, and the staging register holds 0.
- R2: An in-window write with byte-address bit 1 = 0 stores `bus_wdata` in the staging register and raises no strobe.
- R3: An in-window write with byte-address bit 1 = 1 raises `sr_stb` in the cycle its acknowledge is high. The strobe carries `sr_data` = {`bus_wdata`, staged low half}.
- R4: The register index is byte-address bits 7..2 (0 to 63), presented zero-extended on the 8-bit `sr_addr`. Register 63 is reachable at window offsets 0xFC and 0xFE.
- R5: A high-half write with no earlier low-half write uses the current staging value. After reset that value is 0.
- R6: A write is ignored if address bits 10..8 differ from the window select, which defaults to 3'b100 (byte base 0x400), or if byte-address bit 0 is 1. An ignored write produces no strobe and leaves the staging register unchanged, but it is still acknowledged.
- R7: Reads are acknowledged with `bus_rdata` = 0. They produce no strobe and leave the staging register unchanged.
- R8: `sr_stb` is high for exactly one cycle per high-half write. `sr_addr` and `sr_data` keep their values while `sr_stb` is low.
- R9: Every request (`bus_cyc` and `bus_stb` high) is acknowledged in the cycle after it is first seen. The acknowledge lasts one cycle, and no acknowledge appears without a request.
- R10: The staging register keeps its value across high-half writes. Two high-half writes in a row therefore share the same low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_ack | output | 1 | Access acknowledge |
| bus_rdata | output | 16 | Read data, always zero |
| sr_stb | output | 1 | Settings write strobe, one cycle |
| sr_addr | output | 8 | Settings register index |
| sr_data | output | 32 | Settings write data |

## Verification
A request presented before a clock edge yields, just after that one edge, the acknowledge and any strobe with its address and data. A low-half write changes only the hidden staging register, and that change becomes visible one access later, through the data carried by the next high-half strobe. The bench drives each access on a falling edge and samples ack, strobe and settings outputs on the next falling edge. It samples again one cycle later to confirm that the acknowledge and strobe have dropped while the address and data hold.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
    localparam int SR_COUNT  = 64;
    localparam int IDX_W     = $clog2(SR_COUNT);
    localparam int SR_ADDR_W = 8;
    localparam int HALF_W    = 16;
    localparam int WORD_W    = 2 * HALF_W;

    typedef struct packed {
        logic             hit;
        logic             upper;
        logic [IDX_W-1:0] idx;
    } sbb_dec_t;

    typedef struct packed {
        logic [SR_ADDR_W-1:0] addr;
        logic [WORD_W-1:0]    data;
    } sbb_word_t;

    function automatic logic [SR_ADDR_W-1:0] idx_to_addr(input logic [IDX_W-1:0] i);
        return {{(SR_ADDR_W-IDX_W){1'b0}}, i};
    endfunction
endpackage

// File: rtl/sbb_decode.sv
module sbb_decode
    import sbb_pkg::*;
#(
    parameter int                BUS_AW  = 11,
    parameter logic [BUS_AW-9:0] WIN_SEL = 3'b100
) (
    input  logic [BUS_AW-1:0] addr,
    output sbb_dec_t          dec
);
    always_comb begin
        dec.hit   = (addr[BUS_AW-1:8] == WIN_SEL) && !addr[0];
        dec.upper = addr[1];
        dec.idx   = addr[IDX_W+1:2];
    end
endmodule

// File: rtl/sbb_ack.sv
module sbb_ack (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic ack,
    output logic accept
);
    logic ack_q;

    assign accept = req && !ack_q;
    assign ack    = ack_q;

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= accept;
    end

    a_r9_ack_follows: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> ack);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(req));
endmodule

// File: rtl/sbb_assemble.sv
module sbb_assemble
    import sbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              we,
    input  sbb_dec_t          dec,
    input  logic [HALF_W-1:0] wdata,
    output logic              stb,
    output sbb_word_t         word
);
    logic [HALF_W-1:0] stage_q;
    logic              wr_hit;

    assign wr_hit = accept && we && dec.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            stb     <= 1'b0;
            word    <= '0;
        end else begin
            stb <= 1'b0;
            if (wr_hit) begin
                if (!dec.upper) begin
                    stage_q <= wdata;
                end else begin
                    stb       <= 1'b1;
                    word.addr <= idx_to_addr(dec.idx);
                    word.data <= {wdata, stage_q};
                end
            end
        end
    end

    // R8: strobe is a single-cycle pulse, outputs hold between strobes
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !stb |-> $stable(word));
    // R2: a lower-half write never strobes
    a_r2_low_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !dec.upper) |=> !stb);
endmodule

// File: rtl/sb_bridge_16to32.sv
module sb_bridge_16to32
    import sbb_pkg::*;
#(
    parameter int                BUS_AW  = 11,
    parameter logic [BUS_AW-9:0] WIN_SEL = 3'b100
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_cyc,
    input  logic                 bus_stb,
    input  logic                 bus_we,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [HALF_W-1:0]    bus_wdata,
    output logic                 bus_ack,
    output logic [HALF_W-1:0]    bus_rdata,
    output logic                 sr_stb,
    output logic [SR_ADDR_W-1:0] sr_addr,
    output logic [WORD_W-1:0]    sr_data
);
    sbb_dec_t  dec;
    sbb_word_t word;
    logic      req;
    logic      accept;

    assign req       = bus_cyc && bus_stb;
    assign bus_rdata = '0;

    sbb_decode #(.BUS_AW(BUS_AW), .WIN_SEL(WIN_SEL)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    sbb_ack u_ack (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .ack    (bus_ack),
        .accept (accept)
    );

    sbb_assemble u_asm (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .we     (bus_we),
        .dec    (dec),
        .wdata  (bus_wdata),
        .stb    (sr_stb),
        .word   (word)
    );

    assign sr_addr = word.addr;
    assign sr_data = word.data;

    // R3: a strobe only appears alongside the acknowledge of its access
    a_r3_stb_with_ack: assert property (@(posedge clk) disable iff (rst)
        sr_stb |-> bus_ack);
    // R6: accesses outside the window never strobe
    a_r6_outside_quiet: assert property (@(posedge clk) disable iff (rst)
        (accept && !dec.hit) |=> !sr_stb);
    // R7: reads never strobe
    a_r7_read_quiet: assert property (@(posedge clk) disable iff (rst)
        (accept && !bus_we) |=> !sr_stb);
endmodule

// File: tb/sb_bridge_16to32_bench.sv
`timescale 1ns/1ps
module sb_bridge_16to32_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_ack;
    logic [15:0] bus_rdata;
    logic        sr_stb;
    logic [7:0]  sr_addr;
    logic [31:0] sr_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        c_ack, c_stb;
    logic [7:0]  c_addr;
    logic [31:0] c_data;
    logic [15:0] c_rdata;

    always #10 clk = ~clk;

    sb_bridge_16to32 u_sb_bridge_16to32 (
        .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .sr_stb(sr_stb),
        .sr_addr(sr_addr), .sr_data(sr_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One access; captures outputs one edge later, then checks the drop (R8, R9)
    task automatic access(input logic we, input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_cyc = 1; bus_stb = 1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        c_ack = bus_ack; c_stb = sr_stb; c_addr = sr_addr; c_data = sr_data; c_rdata = bus_rdata;
        bus_cyc = 0; bus_stb = 0; bus_we = 0;
        check(c_ack === 1'b1, "R9 ack one cycle after request", {31'd0, c_ack}, 32'd1);
        @(negedge clk);
        check(bus_ack === 1'b0, "R9 ack lasts one cycle", {31'd0, bus_ack}, 32'd0);
        check(sr_stb === 1'b0, "R8 strobe lasts one cycle", {31'd0, sr_stb}, 32'd0);
        check(sr_data === c_data && sr_addr === c_addr, "R8 outputs hold", sr_data, c_data);
    endtask

    function automatic logic [10:0] lo_a(input int n);
        return 11'h400 + 11'(4 * n);
    endfunction

    task automatic expect_strobe(input string tag, input logic [7:0] ea, input logic [31:0] ed);
        check(c_stb === 1'b1, tag, {31'd0, c_stb}, 32'd1);
        check(c_addr === ea, tag, {24'd0, c_addr}, {24'd0, ea});
        check(c_data === ed, tag, c_data, ed);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(sr_stb === 0 && bus_ack === 0, "R1 reset controls", {30'd0, sr_stb, bus_ack}, 32'd0);
        check(sr_data === 0 && sr_addr === 0, "R1 reset outputs", sr_data, 32'd0);
    endtask

    task automatic t_orphan_high;
        access(1, lo_a(5) + 11'd2, 16'hBEEF);
        expect_strobe("R5 orphan high uses reset staging R1", 8'd5, 32'hBEEF_0000);
    endtask

    task automatic t_pair;
        access(1, lo_a(0), 16'h1234);
        check(c_stb === 1'b0, "R2 low half no strobe", {31'd0, c_stb}, 32'd0);
        access(1, lo_a(0) + 11'd2, 16'hABCD);
        expect_strobe("R3 pair assembled", 8'd0, 32'hABCD_1234);
    endtask

    task automatic t_last_reg;
        access(1, 11'h4FC, 16'h5A5A);
        access(1, 11'h4FE, 16'hC3C3);
        expect_strobe("R4 register 63", 8'd63, 32'hC3C3_5A5A);
    endtask

    task automatic t_reuse;
        access(1, lo_a(10) + 11'd2, 16'h0F0F);
        expect_strobe("R10 staging reused", 8'd10, 32'h0F0F_5A5A);
    endtask

    task automatic t_outside;
        access(1, 11'h380, 16'hFFFF);
        check(c_stb === 1'b0, "R6 outside low no strobe", {31'd0, c_stb}, 32'd0);
        access(1, 11'h382, 16'hFFFF);
        check(c_stb === 1'b0, "R6 outside high no strobe", {31'd0, c_stb}, 32'd0);
        access(1, lo_a(3) + 11'd1, 16'hEEEE);
        check(c_stb === 1'b0, "R6 misaligned no strobe", {31'd0, c_stb}, 32'd0);
        access(1, lo_a(2) + 11'd2, 16'h1111);
        expect_strobe("R6 staging untouched", 8'd2, 32'h1111_5A5A);
    endtask

    task automatic t_read;
        access(0, lo_a(7), 16'h7777);
        check(c_rdata === 16'h0, "R7 read data zero", {16'd0, c_rdata}, 32'd0);
        check(c_stb === 1'b0, "R7 read no strobe", {31'd0, c_stb}, 32'd0);
        access(0, lo_a(7) + 11'd2, 16'h7777);
        check(c_stb === 1'b0, "R7 read high no strobe", {31'd0, c_stb}, 32'd0);
        access(1, lo_a(7) + 11'd2, 16'h2222);
        expect_strobe("R7 staging untouched by read", 8'd7, 32'h2222_5A5A);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset;
        t_orphan_high;
        t_pair;
        t_last_reg;
        t_reuse;
        t_outside;
        t_read;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule